// File: doc/BRIEF.md
# Serial Divider-Setting Loader

This block accepts a three-wire serial write (serial clock, serial data, load strobe) and turns it into the divide settings used by a frequency synthesizer's counters. The three pins are sampled in the block's own system clock. Each rising edge of the serial clock pushes one data bit into a shift register. A rising edge of the load strobe copies the word into one of two holding registers. The last bit shifted in is the destination bit. It selects either the reference divide ratio or the main divide setting, which is made of a program count and a swallow count.

The held values are registered outputs. They stay constant between loads, so the counter logic can use them directly. A write that asks for a ratio or a program count below the smallest usable value is still stored, and it raises a sticky range-error flag that only reset clears. Software normally shifts 19 bits, most significant bit first, and then pulses the load strobe.

Top module: `synth_prog_if`

## Requirements
- R1: After synchronous reset the outputs are: reference ratio 5, program count 5, swallow count 0, range error 0.
- R2: Only rising edges of the serial clock shift data. Data changes while the serial clock stays still have no effect. Only the last 19 bits shifted before a load are used; earlier bits fall out.
- R3: Let w[18:0] be the last 19 bits, with w[0] the last one shifted in. When w[0]=1, a load sets the reference ratio to w[18:5]. Program count and swallow count keep their values.
- R4: When w[0]=0, a load sets the program count to w[18:7] and the swallow count to w[6:1]. The reference ratio keeps its value.
- R5: In a reference write, bits w[4:1] have no effect on any output.
- R6: A transfer happens only on a rising edge of the load strobe. Shifting while the strobe is held high loads nothing until the strobe falls and rises again.
- R7: A load with a reference ratio below 5 or a program count below 5 still stores the value and sets the range error. Values of exactly 5, and any swallow count including 0, do not set it.
- R8: Once set, the range error stays 1 until reset, whatever later loads do.
- R9: Outputs change only as the result of a load (or reset).
- R10: New values appear on the outputs at the second system clock edge that samples the load strobe high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | Load strobe; rising edge transfers the word |
| ref_ratio_o | output | 14 | Held reference divide ratio |
| prog_cnt_o | output | 12 | Held program count |
| swal_cnt_o | output | 6 | Held swallow count |
| range_err_o | output | 1 | Sticky flag for a below-minimum ratio or program count |

## Verification
A corrupted shift register shows up only at the next load, as a wrong value in whichever output the destination bit selects. A decoding error shows up the same way, or as a change in the output that should have kept its value. Both appear two system clocks after the load strobe is sampled high. A bad edge detector shows up as outputs that change while the strobe is held high, or that never change. The bench tracks the expected outputs on every clock, so any output that moves outside a load is caught within one cycle.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
  localparam int DEF_REF_W  = 14;
  localparam int DEF_PROG_W = 12;
  localparam int DEF_SWAL_W = 6;
  localparam int DEF_MIN    = 5;

  typedef enum logic {
    SEL_MAIN = 1'b0,
    SEL_REF  = 1'b1
  } dest_e;
endpackage

// File: rtl/synprog_edge.sv
module synprog_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] s_q;
  logic [W-1:0] s_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= '0;
      s_d <= '0;
    end else begin
      s_q <= din;
      s_d <= s_q;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_rise
      assign rise[gi] = s_q[gi] & ~s_d[gi];
    end
  endgenerate
endmodule

// File: rtl/synprog_shifter.sv
module synprog_shifter #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (shift_en) sr <= {sr[W-2:0], din};
  end
endmodule

// File: rtl/synprog_latches.sv
module synprog_latches
  import synprog_pkg::*;
#(
  parameter int REF_W     = DEF_REF_W,
  parameter int PROG_W    = DEF_PROG_W,
  parameter int SWAL_W    = DEF_SWAL_W,
  parameter int MIN_RATIO = DEF_MIN,
  localparam int WORD_W   = PROG_W + SWAL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [REF_W-1:0]  ref_o,
  output logic [PROG_W-1:0] prog_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic              err_o
);
  localparam logic [REF_W-1:0]  REF_MIN  = REF_W'(MIN_RATIO);
  localparam logic [PROG_W-1:0] PROG_MIN = PROG_W'(MIN_RATIO);

  dest_e             dest;
  logic [REF_W-1:0]  ref_new;
  logic [PROG_W-1:0] prog_new;
  logic [SWAL_W-1:0] swal_new;
  logic              bad_ref;
  logic              bad_prog;

  assign dest     = dest_e'(word[0]);
  assign ref_new  = word[WORD_W-1 -: REF_W];
  assign prog_new = word[WORD_W-1 -: PROG_W];
  assign swal_new = word[SWAL_W:1];
  assign bad_ref  = ref_new < REF_MIN;
  assign bad_prog = prog_new < PROG_MIN;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_o  <= REF_MIN;
      prog_o <= PROG_MIN;
      swal_o <= '0;
      err_o  <= 1'b0;
    end else if (load) begin
      case (dest)
        SEL_REF: begin
          ref_o <= ref_new;
          err_o <= err_o | bad_ref;
        end
        default: begin
          prog_o <= prog_new;
          swal_o <= swal_new;
          err_o  <= err_o | bad_prog;
        end
      endcase
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synprog_pkg::*;
#(
  parameter int REF_W     = DEF_REF_W,
  parameter int PROG_W    = DEF_PROG_W,
  parameter int SWAL_W    = DEF_SWAL_W,
  parameter int MIN_RATIO = DEF_MIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_load_i,
  output logic [REF_W-1:0]  ref_ratio_o,
  output logic [PROG_W-1:0] prog_cnt_o,
  output logic [SWAL_W-1:0] swal_cnt_o,
  output logic              range_err_o
);
  localparam int WORD_W = PROG_W + SWAL_W + 1;

  logic [1:0]        rise;
  logic              dat_q;
  logic              shift_stb;
  logic              load_stb;
  logic [WORD_W-1:0] sr_q;

  synprog_edge #(.W(2)) edge_i (
    .clk  (clk),
    .rst  (rst),
    .din  ({ser_load_i, ser_clk_i}),
    .rise (rise)
  );

  always_ff @(posedge clk) begin
    if (rst) dat_q <= 1'b0;
    else     dat_q <= ser_dat_i;
  end

  assign shift_stb = rise[0];
  assign load_stb  = rise[1];

  synprog_shifter #(.W(WORD_W)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_stb),
    .din      (dat_q),
    .sr       (sr_q)
  );

  synprog_latches #(
    .REF_W     (REF_W),
    .PROG_W    (PROG_W),
    .SWAL_W    (SWAL_W),
    .MIN_RATIO (MIN_RATIO)
  ) latch_i (
    .clk    (clk),
    .rst    (rst),
    .load   (load_stb),
    .word   (sr_q),
    .ref_o  (ref_ratio_o),
    .prog_o (prog_cnt_o),
    .swal_o (swal_cnt_o),
    .err_o  (range_err_o)
  );
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
  parameter int REF_W     = 14,
  parameter int PROG_W    = 12,
  parameter int SWAL_W    = 6,
  parameter int MIN_RATIO = 5,
  localparam int WORD_W   = PROG_W + SWAL_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              load_stb,
  input logic [WORD_W-1:0] word,
  input logic [REF_W-1:0]  ref_o,
  input logic [PROG_W-1:0] prog_o,
  input logic [SWAL_W-1:0] swal_o,
  input logic              err_o
);
  localparam logic [REF_W-1:0]  REF_MIN  = REF_W'(MIN_RATIO);
  localparam logic [PROG_W-1:0] PROG_MIN = PROG_W'(MIN_RATIO);

  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ref_o == REF_MIN && prog_o == PROG_MIN && swal_o == '0 && !err_o));

  a_r3_ref_loaded: assert property (@(posedge clk) disable iff (rst)
    (load_stb && word[0]) |=> (ref_o == $past(word[WORD_W-1 -: REF_W])));

  a_r3_main_kept: assert property (@(posedge clk) disable iff (rst)
    (load_stb && word[0]) |=> ($stable(prog_o) && $stable(swal_o)));

  a_r4_ref_kept: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !word[0]) |=> $stable(ref_o));

  a_r7_flag_on_low_ref: assert property (@(posedge clk) disable iff (rst)
    (load_stb && word[0] && word[WORD_W-1 -: REF_W] < REF_MIN) |=> err_o);

  a_r7_flag_on_low_prog: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !word[0] && word[WORD_W-1 -: PROG_W] < PROG_MIN) |=> err_o);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  a_r9_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> ($stable(ref_o) && $stable(prog_o) && $stable(swal_o) && $stable(err_o)));
endmodule

bind synth_prog_if synth_prog_if_chk #(
  .REF_W     (REF_W),
  .PROG_W    (PROG_W),
  .SWAL_W    (SWAL_W),
  .MIN_RATIO (MIN_RATIO)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .load_stb (load_stb),
  .word     (sr_q),
  .ref_o    (ref_ratio_o),
  .prog_o   (prog_cnt_o),
  .swal_o   (swal_cnt_o),
  .err_o    (range_err_o)
);

// File: tb/synth_prog_if_tb_top.sv
module synth_prog_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_load = 1'b0;
  logic [13:0] ref_ratio;
  logic [11:0] prog_cnt;
  logic [5:0]  swal_cnt;
  logic        range_err;

  int checks = 0;
  int failures = 0;
  int pending = 4;
  bit in_reset = 1'b1;

  bit q_bits[$];
  int exp_ref = 5;
  int exp_prog = 5;
  int exp_swal = 0;
  int exp_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_if dut_i (
    .clk         (clk),
    .rst         (rst),
    .ser_clk_i   (ser_clk),
    .ser_dat_i   (ser_dat),
    .ser_load_i  (ser_load),
    .ref_ratio_o (ref_ratio),
    .prog_cnt_o  (prog_cnt),
    .swal_cnt_o  (swal_cnt),
    .range_err_o (range_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison with the model (R9: nothing moves outside a load)
  always @(negedge clk) begin
    if (in_reset) begin
    end else if (pending > 0) begin
      pending--;
    end else begin
      chk("R9", "ref", int'(ref_ratio), exp_ref);
      chk("R9", "prog", int'(prog_cnt), exp_prog);
      chk("R9", "swal", int'(swal_cnt), exp_swal);
      chk("R9", "err", int'(range_err), exp_err);
    end
  end

  function automatic logic [18:0] last_word();
    logic [18:0] w = '0;
    int n = q_bits.size();
    for (int i = 0; i < WORD_W; i++)
      if (n - 1 - i >= 0) w[i] = q_bits[n-1-i];
    return w;
  endfunction

  function automatic logic [18:0] mk_ref(input int r, input int junk);
    logic [13:0] rr = r[13:0];
    logic [3:0]  jj = junk[3:0];
    return {rr, jj, 1'b1};
  endfunction

  function automatic logic [18:0] mk_main(input int p, input int s);
    logic [11:0] pp = p[11:0];
    logic [5:0]  ss = s[5:0];
    return {pp, ss, 1'b0};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    step(1);
    in_reset = 1'b1;
    rst = 1'b1;
    ser_clk = 1'b0;
    ser_load = 1'b0;
    step(3);
    rst = 1'b0;
    q_bits.delete();
    exp_ref = 5; exp_prog = 5; exp_swal = 0; exp_err = 0;
    pending = 2;
    in_reset = 1'b0;
  endtask

  task automatic send_bit(input bit b);
    ser_dat = b;
    step(2);
    ser_clk = 1'b1;
    q_bits.push_back(b);
    step(3);
    ser_clk = 1'b0;
    step(2);
  endtask

  task automatic send_word(input logic [18:0] w);
    for (int i = WORD_W - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic le_rise();
    logic [18:0] w = last_word();
    ser_load = 1'b1;
    if (w[0]) begin
      exp_ref = int'(w[18:5]);
      if (exp_ref < 5) exp_err = 1;
    end else begin
      exp_prog = int'(w[18:7]);
      exp_swal = int'(w[6:1]);
      if (exp_prog < 5) exp_err = 1;
    end
    pending = 3;
  endtask

  task automatic le_fall();
    ser_load = 1'b0;
    step(2);
  endtask

  task automatic write_word(input logic [18:0] w);
    send_word(w);
    le_rise();
    step(3);
    le_fall();
    step(2);
  endtask

  task automatic check_all(input string req, input int r, input int p, input int s, input int e);
    chk(req, "ref", int'(ref_ratio), r);
    chk(req, "prog", int'(prog_cnt), p);
    chk(req, "swal", int'(swal_cnt), s);
    chk(req, "err", int'(range_err), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    step(2);
    // R1: reset values
    check_all("R1", 5, 5, 0, 0);

    // R4: main write, reference kept
    write_word(mk_main(1234, 37));
    check_all("R4", 5, 1234, 37, 0);

    // R3 / R5: reference write with nonzero ignored bits, main kept
    write_word(mk_ref(16383, 4'b1010));
    check_all("R3", 16383, 1234, 37, 0);
    write_word(mk_ref(200, 4'b0101));
    chk("R5", "ref", int'(ref_ratio), 200);
    write_word(mk_ref(200, 4'b1111));
    check_all("R5", 200, 1234, 37, 0);

    // R7 boundary: exactly 5 and swallow 0 raise nothing
    write_word(mk_ref(5, 0));
    write_word(mk_main(5, 0));
    check_all("R7", 5, 5, 0, 0);

    // R2: extra leading bits fall out; only the last 19 count
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    write_word(mk_ref(777, 3));
    chk("R2", "ref", int'(ref_ratio), 777);
    chk("R2", "prog", int'(prog_cnt), 5);

    // R2: data toggling with a still serial clock shifts nothing
    send_word(mk_main(900, 12));
    for (int i = 0; i < 8; i++) begin
      ser_dat = ~ser_dat;
      step(3);
    end
    le_rise(); step(3); le_fall(); step(2);
    check_all("R2", 777, 900, 12, 0);

    // R6: load strobe held high while a new word is shifted
    send_word(mk_main(2000, 1));
    le_rise();
    step(4);
    send_word(mk_ref(4000, 0));
    chk("R6", "ref held", int'(ref_ratio), 777);
    chk("R6", "prog", int'(prog_cnt), 2000);
    le_fall();
    step(3);
    chk("R6", "ref after fall", int'(ref_ratio), 777);
    le_rise(); step(3); le_fall(); step(2);
    chk("R6", "ref after new rise", int'(ref_ratio), 4000);

    // R10: exact load latency
    send_word(mk_main(100, 63));
    le_rise();
    @(negedge clk);
    @(negedge clk);
    chk("R10", "prog before 2nd edge", int'(prog_cnt), 2000);
    @(negedge clk);
    chk("R10", "prog at 2nd edge", int'(prog_cnt), 100);
    chk("R10", "swal at 2nd edge", int'(swal_cnt), 63);
    step(1);
    le_fall();
    step(2);

    // R7: low reference ratio is stored and flagged
    write_word(mk_ref(3, 0));
    check_all("R7", 3, 100, 63, 1);

    // R8: flag survives later valid writes
    write_word(mk_ref(50, 0));
    write_word(mk_main(300, 9));
    check_all("R8", 50, 300, 9, 1);

    // R1 / R8: reset clears the flag and restores minima
    do_reset();
    step(2);
    check_all("R1", 5, 5, 0, 0);

    // R7: low program count is stored and flagged
    write_word(mk_main(4, 20));
    check_all("R7", 5, 4, 20, 1);

    step(5);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule